// File: doc/BRIEF.md
# Coarse Delay Counter

This block stretches a short, precisely timed delay into a long one by counting base-clock periods. A delay word is written ahead of time through a load strobe into a holding register. A start pulse copies it into two counters. The fast counter takes the low half of the word and steps down on every enabled base clock. The slow counter takes the high half and steps down once per 2^PRE_W enabled base clocks. A fixed power-of-two prescaler, cleared when a count is launched, paces the slow counter.

The fast half drains first. The prescaler then begins pacing the slow half. The total span from start to done is therefore `low + 2^PRE_W * high` base clocks. At the default widths, with a 6.25 MHz base clock, that runs from 160 ns per step up to beyond 100 s.

A synchronous clear input abandons a count at any point. An enable input pauses counting without losing any state. A busy flag marks a count in progress, and a one-cycle done pulse marks its end.

Top module: `cdly_coarse_delay`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `busy` and `done` are both 0.
- R2: A start accepted at clock edge 0, with held word W, raises `done` after edge D and never before. Here D = W[LO_W-1:0] + 2^PRE_W * W[LO_W+HI_W-1:LO_W], and every clock edge of the count has `en` high.
- R3: If the held word is all zeros, an accepted start raises `done` after that same start edge, and `busy` stays 0.
- R4: `done` lasts exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R5: A start pulse that arrives while `busy` is 1 is ignored, and the running count still ends at its original edge.
- R6: A load strobe `ld` during a count leaves that count's length unchanged. The next accepted start uses the newly loaded word.
- R7: Every clock edge with `en` low freezes the prescaler and both counters, so each such edge delays `done` by exactly one cycle. `busy` stays 1 throughout.
- R8: `clr` high at an edge drops `busy` and suppresses `done`, and no `done` follows from the abandoned count. The held word is kept, and the next start runs a full count.
- R9: A start accepted with a nonzero held word raises `busy` after the start edge, and `busy` stays 1 until the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, prescaler and busy |
| en | input | 1 | Count enable; low freezes the count |
| ld | input | 1 | Load strobe for the held delay word |
| ld_word | input | LO_W+HI_W | Delay word; the low LO_W bits feed the fast counter |
| start | input | 1 | Launch a count when idle |
| busy | output | 1 | A count is in progress |
| done | output | 1 | One-cycle pulse at the end of a count |

## Verification
Every result is defined in clock edges from the start edge, taken as edge 0. `done` is due after edge D, shifted by one edge for every edge with `en` low. `busy` is due after edge 0, and the effect of `clr` is due after the edge that samples it. The bench drives inputs on falling edges and counts falling edges after the start edge until `done` appears. It compares that count with D, computed arithmetically from the word. It sweeps every word of a 3/3/3-bit instance and adds two words on a full 16/16/16-bit instance, one of which crosses a prescaler period.

// File: rtl/cdly_pkg.sv
package cdly_pkg;
  typedef enum logic {
    CD_IDLE = 1'b0,
    CD_RUN  = 1'b1
  } cd_state_e;
endpackage

// File: rtl/cdly_downcnt.sv
// Loadable down counter that holds at zero.
module cdly_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_one
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (load)                cnt_d = load_val;
    else if (dec && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == W'(1));
endmodule

// File: rtl/cdly_prescaler.sv
// Fixed divide-by-2^P prescaler; tick marks the enabled edge that wraps it.
module cdly_prescaler #(
  parameter int P = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [P-1:0] cnt,
  output logic         tick
);
  localparam logic [P-1:0] LAST = '1;
  logic [P-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign tick = run && !clr && (cnt_q == LAST);
endmodule

// File: rtl/cdly_coarse_delay.sv
module cdly_coarse_delay
  import cdly_pkg::*;
#(
  parameter int LO_W  = 16,
  parameter int HI_W  = 16,
  parameter int PRE_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 ld,
  input  logic [LO_W+HI_W-1:0] ld_word,
  input  logic                 start,
  output logic                 busy,
  output logic                 done
);
  localparam int WORD_W = LO_W + HI_W;

  cd_state_e         state_q, state_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              done_q, done_d;

  logic [LO_W-1:0]   lo_cnt;
  logic [HI_W-1:0]   hi_cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic              lo_zero, lo_one, hi_zero, hi_one, pre_tick;
  logic              running, start_ok, word_zero;
  logic              lo_dec, pre_run, hi_dec, finish;

  // held word: new loads never touch a count in flight
  always_comb begin
    shadow_d = shadow_q;
    if (ld) shadow_d = ld_word;
  end

  assign running   = (state_q == CD_RUN);
  assign start_ok  = start && !running && !clr;
  assign word_zero = (shadow_q == '0);

  // fast half drains first, then the prescaler paces the slow half
  assign lo_dec  = running && en && !clr && !lo_zero;
  assign pre_run = running && en && !clr && lo_zero;
  assign hi_dec  = pre_tick && !hi_zero;
  assign finish  = (lo_dec && lo_one && hi_zero) || (hi_dec && hi_one);

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    if (clr) begin
      state_d = CD_IDLE;
    end else if (start_ok) begin
      if (word_zero) done_d  = 1'b1;
      else           state_d = CD_RUN;
    end else if (finish) begin
      state_d = CD_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CD_IDLE;
      shadow_q <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      shadow_q <= shadow_d;
      done_q   <= done_d;
    end
  end

  cdly_downcnt #(.W(LO_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(start_ok),
    .load_val(shadow_q[LO_W-1:0]), .dec(lo_dec),
    .cnt(lo_cnt), .is_zero(lo_zero), .is_one(lo_one)
  );

  cdly_prescaler #(.P(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr || start_ok), .run(pre_run),
    .cnt(pre_cnt), .tick(pre_tick)
  );

  cdly_downcnt #(.W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(start_ok),
    .load_val(shadow_q[WORD_W-1:LO_W]), .dec(hi_dec),
    .cnt(hi_cnt), .is_zero(hi_zero), .is_one(hi_one)
  );

  assign busy = running;
  assign done = done_q;
endmodule

// File: rtl/cdly_coarse_delay_chk.sv
module cdly_coarse_delay_chk #(
  parameter int LO_W  = 16,
  parameter int HI_W  = 16,
  parameter int PRE_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 en,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [LO_W+HI_W-1:0] held,
  input logic [LO_W-1:0]      lo_cnt,
  input logic [HI_W-1:0]      hi_cnt,
  input logic [PRE_W-1:0]     pre_cnt
);
  assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !clr && held == '0) |=> (done && !busy));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !clr) |=> (busy || done));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en && !clr) |=> (busy && !done && $stable(lo_cnt)
                                && $stable(hi_cnt) && $stable(pre_cnt)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !done));

  assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !clr && held != '0) |=> (busy && !done));
endmodule

bind cdly_coarse_delay cdly_coarse_delay_chk #(
  .LO_W(LO_W), .HI_W(HI_W), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .start(start),
  .busy(busy), .done(done), .held(shadow_q),
  .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .pre_cnt(pre_cnt)
);

// File: tb/tb_cdly_coarse_delay.sv
module tb_cdly_coarse_delay;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  // small instance: 3-bit halves, divide-by-8 prescaler
  logic       s_clr, s_en, s_ld, s_start, s_busy, s_done;
  logic [5:0] s_word;
  // full-width instance
  logic        w_clr, w_en, w_ld, w_start, w_busy, w_done;
  logic [31:0] w_word;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  cdly_coarse_delay #(.LO_W(3), .HI_W(3), .PRE_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .en(s_en), .ld(s_ld),
    .ld_word(s_word), .start(s_start), .busy(s_busy), .done(s_done)
  );

  cdly_coarse_delay dut_wide (
    .clk(clk), .rst_n(rst_n), .clr(w_clr), .en(w_en), .ld(w_ld),
    .ld_word(w_word), .start(w_start), .busy(w_busy), .done(w_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int span(input int w);
    return (w & 7) + 8 * ((w >> 3) & 7);
  endfunction

  task automatic load_small(input int w);
    @(negedge clk); s_ld = 1'b1; s_word = 6'(w);
    @(negedge clk); s_ld = 1'b0;
  endtask

  // start pulse; returns at the falling edge after start edge 0
  task automatic fire_small;
    s_start = 1'b1;
    @(negedge clk); s_start = 1'b0;
  endtask

  task automatic wait_done_small(inout int n);
    while (!s_done && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic sweep_word(input int w);
    int n = 0;
    int d = span(w);
    load_small(w);
    fire_small();
    if (d == 0)
      check(s_done && !s_busy, "R3", "zero word done/busy", {s_done, s_busy}, 2);
    else
      check(s_busy && !s_done, "R9", "busy after start", {s_busy, s_done}, 2);
    wait_done_small(n);
    check(n == d, "R2", $sformatf("latency word=%0d", w), n, d);
    check(!s_busy, "R4", "busy with done", s_busy, 0);
    @(negedge clk);
    check(!s_done && !s_busy, "R4", "done single cycle", s_done, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    s_clr = 0; s_en = 1; s_ld = 0; s_start = 0; s_word = '0;
    w_clr = 0; w_en = 1; w_ld = 0; w_start = 0; w_word = '0;
    repeat (3) @(negedge clk);
    check(!s_busy && !s_done && !w_busy && !w_done, "R1", "reset outputs",
          {s_busy, s_done, w_busy, w_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R9: every word of the small instance
    for (int w = 0; w < 64; w++) sweep_word(w);

    // R7: pause during the prescaler phase (lo=3, hi=5 -> 43)
    begin
      int n = 0;
      bit held_busy = 1;
      load_small(6'b101_011);
      fire_small();
      repeat (10) begin @(negedge clk); n++; end
      s_en = 1'b0;
      repeat (7) begin
        @(negedge clk); n++;
        held_busy &= s_busy && !s_done;
      end
      s_en = 1'b1;
      check(held_busy, "R7", "busy held while disabled", held_busy, 1);
      wait_done_small(n);
      check(n == 50, "R7", "latency with slow-phase pause", n, 50);
    end

    // R7: pause during the fast phase (lo=6, hi=0 -> 6)
    begin
      int n = 0;
      load_small(6);
      fire_small();
      repeat (2) begin @(negedge clk); n++; end
      s_en = 1'b0;
      repeat (5) begin @(negedge clk); n++; end
      s_en = 1'b1;
      wait_done_small(n);
      check(n == 11, "R7", "latency with fast-phase pause", n, 11);
    end

    // R5 and R6: extra start and reload mid-count (lo=6, hi=3 -> 30)
    begin
      int n = 0;
      load_small(6'b011_110);
      fire_small();
      repeat (10) begin @(negedge clk); n++; end
      s_start = 1'b1;
      @(negedge clk); n++; s_start = 1'b0;
      s_ld = 1'b1; s_word = 6'd5;
      @(negedge clk); n++; s_ld = 1'b0;
      wait_done_small(n);
      check(n == 30, "R5", "latency after ignored start", n, 30);
      check(n == 30, "R6", "reload does not disturb count", n, 30);
      @(negedge clk);
      n = 0;
      fire_small();
      wait_done_small(n);
      check(n == 5, "R6", "next start uses reloaded word", n, 5);
    end

    // R8: clear mid-count, then a full count from a clean start
    begin
      int n = 0;
      bit seen = 0;
      load_small(6'b010_100);
      fire_small();
      repeat (5) @(negedge clk);
      s_clr = 1'b1;
      @(negedge clk); s_clr = 1'b0;
      check(!s_busy && !s_done, "R8", "busy after clear", s_busy, 0);
      repeat (30) begin @(negedge clk); seen |= s_done; end
      check(!seen, "R8", "no done after clear", seen, 0);
      fire_small();
      wait_done_small(n);
      check(n == 20, "R8", "full count after clear", n, 20);
    end

    // R1: asynchronous reset mid-count
    begin
      load_small(6'b111_111);
      fire_small();
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(!s_busy && !s_done, "R1", "reset mid-count", s_busy, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
    end

    // R2 on the full-width instance: fast half only, then across one prescaler period
    begin
      int n = 0;
      int lim = 70000;
      @(negedge clk); w_ld = 1'b1; w_word = 32'd5;
      @(negedge clk); w_ld = 1'b0; w_start = 1'b1;
      @(negedge clk); w_start = 1'b0;
      while (!w_done && n < lim) begin @(negedge clk); n++; end
      check(n == 5, "R2", "wide latency low-only", n, 5);
      n = 0;
      @(negedge clk); w_ld = 1'b1; w_word = 32'h0001_0003;
      @(negedge clk); w_ld = 1'b0; w_start = 1'b1;
      @(negedge clk); w_start = 1'b0;
      while (!w_done && n < lim) begin @(negedge clk); n++; end
      check(n == 65539, "R2", "wide latency both halves", n, 65539);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule